// File: doc/BRIEF.md
# Multi-Format Serial Receiver with Format-Dependent Event Timing

This block receives asynchronous serial frames using a clock enable that pulses sixteen times per bit period. It accepts five frame layouts, selected by a 3-bit format code. Each frame has a start bit, a data field of 7, 8 or 9 bits sent least significant bit first, an optional parity bit and one stop bit. A two-flop synchronizer feeds a bit-timing engine. The engine validates the start bit, samples every bit at its centre and hands the completed word to a one-deep holding buffer. Host logic reads the word from that buffer.

The instant at which a frame is reported depends on the format. Short frames are reported at the centre of the stop bit. The 9-bit and 8-bit-plus-parity frames are reported one bit period earlier, at the centre of their last bit, before the stop bit has been seen. Error flags for parity, framing and overrun are sticky and are each raised at a defined sample point. A small companion timer models the matching transmitter's interrupt: it pulses just before that transmitter would begin driving its stop bit.

Top module: `uart_evt_rx`

## Requirements
- R1: The format code `fmt` selects the layout: 0 = 7 data bits, 1 = 7 data bits plus parity, 2 = 8 data bits, 3 = 8 data bits plus parity, 4 = 9 data bits. Data arrives LSB first. The received word appears right-aligned on `rx_data`, the bits above the data field read zero, and the parity bit is never stored.
- R2: A falling edge on the line starts a frame only if the line is still low at the 8th tick after the edge is seen. A shorter low pulse yields no word and no `rx_irq`, and the next valid frame is received normally.
- R3: `rx_irq` is a single-clock pulse, once per frame. For codes 0, 1 and 2 it fires at the centre sample of the stop bit.
- R4: For codes 3 and 4, `rx_irq` fires at the centre sample of the last bit (parity bit or data bit 8). This is exactly 16 ticks before the stop-bit centre sample.
- R5: `err_frame` is set when the stop bit is sampled low at its centre. For codes 3 and 4 it rises 16 ticks after `rx_irq`. For codes 0, 1 and 2 it is already high in the cycle that `rx_irq` is high.
- R6: `parity_odd` selects the parity sense: 0 means the data bits plus the parity bit hold an even number of ones, and 1 means an odd number. `err_parity` is set at the parity-bit centre sample. For code 3 this is the same cycle as `rx_irq`; for code 1 it is 16 ticks earlier.
- R7: The word is moved into the holding buffer at the `rx_irq` instant, and `rx_full` rises with it. A one-cycle `rd_strobe` empties the buffer.
- R8: If a word completes while `rx_full` is still high, `err_overrun` rises in the `rx_irq` cycle and the buffered word is kept. All three error flags remain set until a one-cycle `clr_err`.
- R9: After a one-cycle `tx_launch`, `tx_irq` pulses once, on tick number (1 + data bits + parity bits) x 16 counted from the launch. `tx_busy` falls 16 ticks later, at the end of the stop bit.
- R10: After reset, `rx_data` is zero and every flag, strobe and busy output is low.
- R11: A `tx_launch` received while `tx_busy` is high is ignored. The frame's `tx_irq` tick and `tx_busy` end tick do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_line | input | 1 | Serial receive line, idle high |
| fmt | input | 3 | Frame format code (see R1) |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Host has taken the buffered word |
| clr_err | input | 1 | Clears all sticky error flags |
| tx_launch | input | 1 | Starts one transmit frame timing |
| rx_data | output | 9 | Buffered received word |
| rx_full | output | 1 | Buffer holds an unread word |
| rx_irq | output | 1 | Receive interrupt pulse |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| tx_irq | output | 1 | Transmit interrupt pulse |
| tx_busy | output | 1 | Transmit frame in progress |

## Verification
The hardest situation to reach is the gap between an early report and the framing verdict in the long formats. In that window a broken stop bit must still be invisible when `rx_irq` fires. The bench sends frames whose stop bit is held low for three quarters of a bit and then released. This yields a framing error without the tail of the bad stop bit being taken for a new start. The bench then measures, in clock cycles, how far the flag edge lags the interrupt. Overruns are produced by leaving the buffer unread across two frames, and parity faults by flipping the computed parity bit.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

  localparam int unsigned WORD_W = 9;

  typedef enum logic [2:0] {
    FMT_D7  = 3'd0,
    FMT_D7P = 3'd1,
    FMT_D8  = 3'd2,
    FMT_D8P = 3'd3,
    FMT_D9  = 3'd4
  } fmt_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // number of data bits carried by a format code
  function automatic logic [3:0] data_bits(input logic [2:0] f);
    case (f)
      FMT_D7, FMT_D7P: data_bits = 4'd7;
      FMT_D9:          data_bits = 4'd9;
      default:         data_bits = 4'd8;
    endcase
  endfunction

  function automatic logic has_parity(input logic [2:0] f);
    has_parity = (f == FMT_D7P) || (f == FMT_D8P);
  endfunction

  // formats that report the frame at the centre of the last bit
  function automatic logic early_report(input logic [2:0] f);
    early_report = (f == FMT_D8P) || (f == FMT_D9);
  endfunction

  // bits before the stop bit: start + data + parity
  function automatic logic [3:0] pre_stop_bits(input logic [2:0] f);
    pre_stop_bits = 4'd1 + data_bits(f) + {3'd0, has_parity(f)};
  endfunction

  // 1 when the parity bit disagrees with the data under the chosen sense
  function automatic logic parity_bad(input logic [WORD_W-1:0] d,
                                      input logic [3:0] nb,
                                      input logic pbit,
                                      input logic odd);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(nb)) acc = acc ^ d[i];
    end
    parity_bad = acc ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/uart_line_sync.sv
module uart_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= 1'b1;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_evt_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic [2:0]        fmt,
  input  logic              parity_odd,
  output logic              ev_report,
  output logic [WORD_W-1:0] word_now,
  output logic              ev_par_sample,
  output logic              par_wrong,
  output logic              ev_stop_sample,
  output logic              stop_low
);
  localparam int unsigned PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] MID  = PH_W'(OSR / 2 - 1);
  localparam logic [PH_W-1:0] LAST = PH_W'(OSR - 1);

  rx_state_e          state;
  logic [PH_W-1:0]    phase;
  logic [3:0]         idx;
  logic [WORD_W-1:0]  sh;
  logic [2:0]         fmt_q;
  logic               odd_q;

  logic [3:0] nb;
  logic       at_mid, at_last;
  logic       ev_bit_sample, ev_last_data;

  assign nb      = data_bits(fmt_q);
  assign at_mid  = tick && (phase == MID);
  assign at_last = tick && (phase == LAST);

  assign ev_bit_sample  = at_mid && (state == RX_DATA);
  assign ev_last_data   = ev_bit_sample && (idx == nb - 4'd1);
  assign ev_par_sample  = at_mid && (state == RX_PAR);
  assign ev_stop_sample = at_mid && (state == RX_STOP);

  assign word_now  = ev_bit_sample ? (sh | ({{(WORD_W-1){1'b0}}, rx_s} << idx)) : sh;
  assign par_wrong = parity_bad(sh, nb, rx_s, odd_q);
  assign stop_low  = !rx_s;

  always_comb begin
    if (!early_report(fmt_q))
      ev_report = ev_stop_sample;
    else if (has_parity(fmt_q))
      ev_report = ev_par_sample;
    else
      ev_report = ev_last_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      phase <= '0;
      idx   <= '0;
      sh    <= '0;
      fmt_q <= 3'd0;
      odd_q <= 1'b0;
    end else if (tick) begin
      if (state != RX_IDLE)
        phase <= (phase == LAST) ? '0 : phase + 1'b1;
      case (state)
        RX_IDLE: begin
          if (!rx_s) begin
            state <= RX_START;
            phase <= PH_W'(1);
            idx   <= '0;
            sh    <= '0;
            fmt_q <= fmt;
            odd_q <= parity_odd;
          end
        end
        RX_START: begin
          if (at_mid && rx_s)  state <= RX_IDLE;
          else if (at_last)    state <= RX_DATA;
        end
        RX_DATA: begin
          if (at_mid) sh <= word_now;
          if (at_last) begin
            if (idx == nb - 4'd1) begin
              idx   <= '0;
              state <= has_parity(fmt_q) ? RX_PAR : RX_STOP;
            end else begin
              idx <= idx + 4'd1;
            end
          end
        end
        RX_PAR: begin
          if (at_last) state <= RX_STOP;
        end
        RX_STOP: begin
          if (at_mid) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assert_false_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && at_mid && rx_s) |=> (state == RX_IDLE));

  assert_report_before_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_report && early_report(fmt_q)) |-> (state != RX_STOP));

  assert_report_at_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_report && !early_report(fmt_q)) |-> (state == RX_STOP));

endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_report,
  input  logic [WORD_W-1:0] word_now,
  input  logic              ev_par_sample,
  input  logic              par_wrong,
  input  logic              ev_stop_sample,
  input  logic              stop_low,
  input  logic              rd_strobe,
  input  logic              clr_err,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_irq,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun
);
  logic load_ok, ovr_hit;

  assign load_ok = ev_report && (!rx_full || rd_strobe);
  assign ovr_hit = ev_report && rx_full && !rd_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      rx_irq      <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      rx_irq <= ev_report;
      if (load_ok) begin
        rx_data <= word_now;
        rx_full <= 1'b1;
      end else if (rd_strobe) begin
        rx_full <= 1'b0;
      end
      if (ev_par_sample && par_wrong) err_parity <= 1'b1;
      else if (clr_err)               err_parity <= 1'b0;
      if (ev_stop_sample && stop_low) err_frame <= 1'b1;
      else if (clr_err)               err_frame <= 1'b0;
      if (ovr_hit)      err_overrun <= 1'b1;
      else if (clr_err) err_overrun <= 1'b0;
    end
  end

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  assert_full_after_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_report |=> (rx_full && rx_irq));

  assert_overrun_keeps_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_report && rx_full && !rd_strobe) |=> ($stable(rx_data) && err_overrun));

  assert_frame_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> $past(ev_stop_sample));

  assert_parity_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> $past(ev_par_sample));

endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
  import uart_evt_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] fmt,
  input  logic       tx_launch,
  output logic       tx_irq,
  output logic       tx_busy
);
  localparam int unsigned PH_W = $clog2(OSR);
  localparam logic [PH_W-1:0] LAST = PH_W'(OSR - 1);

  logic [PH_W-1:0] phase;
  logic [3:0]      bitno;
  logic [3:0]      span_q;
  logic            bit_end, ev_pre_stop;

  assign bit_end     = tick && tx_busy && (phase == LAST);
  assign ev_pre_stop = bit_end && (bitno == span_q - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_irq  <= 1'b0;
      phase   <= '0;
      bitno   <= '0;
      span_q  <= '0;
    end else begin
      tx_irq <= ev_pre_stop;
      if (tx_launch && !tx_busy) begin
        tx_busy <= 1'b1;
        phase   <= '0;
        bitno   <= '0;
        span_q  <= pre_stop_bits(fmt);
      end else if (tick && tx_busy) begin
        phase <= (phase == LAST) ? '0 : phase + 1'b1;
        if (phase == LAST) begin
          if (bitno == span_q) tx_busy <= 1'b0;
          else                 bitno   <= bitno + 4'd1;
        end
      end
    end
  end

  assert_tx_irq_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_busy);

  assert_tx_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq);

  assert_launch_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_launch && tx_busy && !bit_end) |=> $stable(bitno));

endmodule

// File: rtl/uart_evt_rx.sv
module uart_evt_rx
  import uart_evt_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_line,
  input  logic [2:0] fmt,
  input  logic       parity_odd,
  input  logic       rd_strobe,
  input  logic       clr_err,
  input  logic       tx_launch,
  output logic [8:0] rx_data,
  output logic       rx_full,
  output logic       rx_irq,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       tx_irq,
  output logic       tx_busy
);
  logic              rx_s;
  logic              ev_report, ev_par_sample, ev_stop_sample;
  logic              par_wrong, stop_low;
  logic [WORD_W-1:0] word_now;

  uart_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (rx_s)
  );

  uart_rx_core #(.OSR(OSR)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick16),
    .rx_s          (rx_s),
    .fmt           (fmt),
    .parity_odd    (parity_odd),
    .ev_report     (ev_report),
    .word_now      (word_now),
    .ev_par_sample (ev_par_sample),
    .par_wrong     (par_wrong),
    .ev_stop_sample(ev_stop_sample),
    .stop_low      (stop_low)
  );

  uart_rx_store u_store (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_report     (ev_report),
    .word_now      (word_now),
    .ev_par_sample (ev_par_sample),
    .par_wrong     (par_wrong),
    .ev_stop_sample(ev_stop_sample),
    .stop_low      (stop_low),
    .rd_strobe     (rd_strobe),
    .clr_err       (clr_err),
    .rx_data       (rx_data),
    .rx_full       (rx_full),
    .rx_irq        (rx_irq),
    .err_parity    (err_parity),
    .err_frame     (err_frame),
    .err_overrun   (err_overrun)
  );

  uart_tx_irq #(.OSR(OSR)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .fmt      (fmt),
    .tx_launch(tx_launch),
    .tx_irq   (tx_irq),
    .tx_busy  (tx_busy)
  );

endmodule

// File: tb/uart_evt_rx_test.sv
`timescale 1ns/1ps
module uart_evt_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [2:0] fmt = 3'd0;
  logic       parity_odd = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       clr_err = 1'b0;
  logic       tx_launch = 1'b0;
  logic [8:0] rx_data;
  logic       rx_full, rx_irq, err_parity, err_frame, err_overrun, tx_irq, tx_busy;
  logic [1:0] div = 2'd0;
  logic       tick16;

  int nvec = 0, nfail = 0;
  int cyc = 0, tk = 0;
  int irq_n = 0, irq_cyc = -1, ferr_cyc = -1, perr_cyc = -1, ovr_cyc = -1;
  int ferr_at_irq = 0;
  int txi_n = 0, txi_tk = -1, txf_tk = -1;
  logic pf = 1'b0, pp = 1'b0, po = 1'b0, pb = 1'b0;
  bit done = 1'b0;

  uart_evt_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line), .fmt(fmt),
    .parity_odd(parity_odd), .rd_strobe(rd_strobe), .clr_err(clr_err),
    .tx_launch(tx_launch), .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .tx_irq(tx_irq), .tx_busy(tx_busy)
  );

  always #2.5 clk = ~clk;
  assign tick16 = (div == 2'd0);
  always @(negedge clk) div <= div + 2'd1;
  always @(posedge clk) if (tick16) tk = tk + 1;

  // event monitor: outputs are stable at the falling edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rx_irq) begin
      irq_n = irq_n + 1;
      irq_cyc = cyc;
      ferr_at_irq = err_frame;
    end
    if (err_frame && !pf)   ferr_cyc = cyc;
    if (err_parity && !pp)  perr_cyc = cyc;
    if (err_overrun && !po) ovr_cyc = cyc;
    if (tx_irq) begin
      txi_n = txi_n + 1;
      txi_tk = tk;
    end
    if (!tx_busy && pb) txf_tk = tk;
    pf = err_frame; pp = err_parity; po = err_overrun; pb = tx_busy;
  end

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nbits(input int f);
    return (f < 2) ? 7 : ((f == 4) ? 9 : 8);
  endfunction
  function automatic int npar(input int f);
    return (f == 1 || f == 3) ? 1 : 0;
  endfunction
  function automatic bit early(input int f);
    return (f == 3 || f == 4);
  endfunction

  task automatic hold(input logic v, input int clocks);
    @(negedge clk) rx_line = v;
    repeat (clocks - 1) @(negedge clk);
  endtask

  task automatic send_frame(input int f, input int od, input int data,
                            input bit flip_par, input bit stop_ok);
    int ones;
    ones = 0;
    fmt = 3'(f);
    parity_odd = od[0];
    irq_cyc = -1; ferr_cyc = -1; perr_cyc = -1; ovr_cyc = -1;
    hold(1'b0, 64);
    for (int i = 0; i < nbits(f); i++) begin
      hold(data[i], 64);
      ones += data[i];
    end
    if (npar(f) == 1) hold(1'(ones % 2) ^ od[0] ^ flip_par, 64);
    if (stop_ok) hold(1'b1, 64);
    else begin
      hold(1'b0, 48);
      hold(1'b1, 16);
    end
    hold(1'b1, 128);
  endtask

  task automatic pulse_rd;
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
    @(negedge clk);
  endtask
  task automatic pulse_clr;
    @(negedge clk) clr_err = 1'b1;
    @(negedge clk) clr_err = 1'b0;
    @(negedge clk);
  endtask

  task automatic tx_run(input int f, input bit relaunch);
    int t0, n0;
    fmt = 3'(f);
    n0 = txi_n;
    @(negedge clk) tx_launch = 1'b1;
    @(negedge clk) tx_launch = 1'b0;
    t0 = tk;
    if (relaunch) begin
      repeat (100) @(negedge clk);
      tx_launch = 1'b1;
      @(negedge clk) tx_launch = 1'b0;
    end
    while (tx_busy) @(negedge clk);
    @(negedge clk);
    chk(relaunch ? "R11 tx irq count" : "R9 tx irq count", txi_n - n0, 1);
    chk(relaunch ? "R11 tx irq tick" : "R9 tx irq tick", txi_tk - t0,
        (1 + nbits(f) + npar(f)) * 16);
    chk(relaunch ? "R11 busy end tick" : "R9 busy end tick", txf_tk - t0,
        (2 + nbits(f) + npar(f)) * 16);
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog (all requirements): actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int pats[6];
    int n0, a, b;
    pats = '{0, 511, 341, 170, 451, 77};
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rx_data", rx_data, 0);
    chk("R10 rx_full", rx_full, 0);
    chk("R10 rx_irq", rx_irq, 0);
    chk("R10 flags", {err_parity, err_frame, err_overrun}, 0);
    chk("R10 tx outputs", {tx_irq, tx_busy}, 0);

    // R1/R3/R4/R6/R7 sweep: formats x parity sense x patterns
    for (int f = 0; f < 5; f++)
      for (int od = 0; od < 2; od++)
        for (int p = 0; p < 6; p++) begin
          a = pats[p] & ((1 << nbits(f)) - 1);
          n0 = irq_n;
          send_frame(f, od, a, 1'b0, 1'b1);
          chk(early(f) ? "R4 one irq" : "R3 one irq", irq_n - n0, 1);
          chk("R1 word", rx_data, a);
          chk("R7 full", rx_full, 1);
          chk("R6 no error", {err_parity, err_frame, err_overrun}, 0);
          pulse_rd();
          chk("R7 read empties", rx_full, 0);
        end

    // R5 framing verdict relative to the report instant
    for (int f = 0; f < 5; f++) begin
      send_frame(f, 0, 90, 1'b0, 1'b0);
      chk("R5 frame flag", err_frame, 1);
      chk(early(f) ? "R4 stop lag" : "R3 stop lag", ferr_cyc - irq_cyc, early(f) ? 64 : 0);
      chk("R5 flag at irq", ferr_at_irq, early(f) ? 0 : 1);
      repeat (200) @(negedge clk);
      chk("R8 frame sticky", err_frame, 1);
      pulse_clr();
      chk("R8 frame cleared", err_frame, 0);
      pulse_rd();
    end

    // R6 parity fault timing, both senses
    for (int od = 0; od < 2; od++) begin
      send_frame(1, od, 37, 1'b1, 1'b1);
      chk("R6 parity flag 7p", err_parity, 1);
      chk("R6 parity lead 7p", irq_cyc - perr_cyc, 64);
      chk("R1 word with bad parity", rx_data, 37);
      pulse_clr(); pulse_rd();
      send_frame(3, od, 200, 1'b1, 1'b1);
      chk("R6 parity flag 8p", err_parity, 1);
      chk("R6 parity lead 8p", irq_cyc - perr_cyc, 0);
      pulse_clr(); pulse_rd();
    end

    // R8 overrun, short and early formats
    for (int k = 0; k < 2; k++) begin
      a = (k == 0) ? 165 : 300;
      b = (k == 0) ? 90 : 211;
      send_frame(k == 0 ? 2 : 4, 0, a, 1'b0, 1'b1);
      chk("R8 no overrun yet", err_overrun, 0);
      n0 = irq_n;
      send_frame(k == 0 ? 2 : 4, 0, b, 1'b0, 1'b1);
      chk("R8 overrun flag", err_overrun, 1);
      chk("R8 old word kept", rx_data, a);
      chk("R8 overrun at irq", ovr_cyc - irq_cyc, 0);
      chk("R3 irq on overrun", irq_n - n0, 1);
      pulse_clr();
      chk("R8 overrun cleared", err_overrun, 0);
      pulse_rd();
    end

    // R2 false start then a good frame
    fmt = 3'd2;
    n0 = irq_n;
    hold(1'b0, 20);
    hold(1'b1, 256);
    chk("R2 no irq on glitch", irq_n - n0, 0);
    chk("R2 buffer empty", rx_full, 0);
    send_frame(2, 1, 129, 1'b0, 1'b1);
    chk("R2 frame after glitch", rx_data, 129);
    pulse_rd();

    // R9 transmit interrupt timing, R11 relaunch ignored
    for (int f = 0; f < 5; f++) tx_run(f, 1'b0);
    tx_run(2, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule